// File: doc/BRIEF.md
# Two-Stage Pulse-Width Glitch Filter

This block cleans up one noisy single-bit synchronous control line, such as a trigger, a wait-for-trigger level or a clear request, so that short glitches cannot reach the logic that consumes the line. The input is assumed to be already synchronised to the block clock. The block has a clock, a synchronous active-high reset, one data input and one filtered output.

Filtering happens in two cascaded stages. The first stage is a width qualifier. It accepts a new level only after the input has held that level for a minimum number of consecutive cycles. The minimum is set separately for high and low. A larger minimum therefore adds delay. The second stage is a hold stage. After every edge of the qualified signal, it keeps the output at the new level for a set number of cycles, again with separate values for high and low. When a hold period ends, the output takes the current qualified level at once. Every parameter must be at least 1, and a value of 1 turns its function off. The usual setting in the field is no width qualification and a hold of 4 cycles for each polarity.

Top module: `gf_glitch_filter`

## Requirements
- R1: With both minimum widths and both hold values at 1, the output equals the input in the same cycle.
- R2: A high pulse shorter than MIN_HI cycles at the input never makes the width-stage result go high.
- R3: A high run of at least MIN_HI cycles makes the width-stage result go high MIN_HI-1 cycles after the run starts. The result then stays high until the low qualifier is met.
- R4: The low polarity behaves in the same way under MIN_LO. A low gap shorter than MIN_LO is removed, and a longer one passes, delayed by MIN_LO-1 cycles.
- R5: After a rising edge of the output, the output stays high for KEEP_HI cycles, counting the edge cycle, whatever the input does.
- R6: After a falling edge of the output, the output stays low for KEEP_LO cycles, counting the edge cycle.
- R7: A hold value of 1 adds no hold, so the output follows the width-stage result in the same cycle.
- R8: When a hold period ends, the output takes the current width-stage level in that same cycle. A level change that arrived during the hold therefore shows up immediately.
- R9: Width qualification comes first, and the hold stage acts only on its result.
- R10: While reset is high, the output and the width-stage result are 0. After reset, the input history counts as all-zero and no hold is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Synchronised noisy input |
| dout | output | 1 | Filtered output |

## Verification
The width-stage result changes MIN_HI-1 or MIN_LO-1 cycles after the qualifying run starts. Both stages are combinational from the current input sample, so with no hold active the output changes in that same cycle. With a hold active, the output changes in the first cycle after the hold ends. The bench drives the input just after the falling clock edge and compares the output 1 ns later. At each clock its reference model takes the input history and the hold state that the edge just committed. Three configurations run side by side: a mixed one, a fully transparent one and the default one. Each is checked against the model on every cycle, including the reset cycles.

// File: rtl/gf_pkg.sv
package gf_pkg;

    // Larger of two non-negative values.
    function automatic int unsigned gf_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Bits needed to hold values 0..n, never less than 1.
    function automatic int unsigned gf_cnt_w(input int unsigned n);
        int unsigned w;
        w = $clog2(n + 1);
        return (w < 1) ? 1 : w;
    endfunction

    // Level encoding used by the hold stage.
    typedef enum logic {
        GF_LOW  = 1'b0,
        GF_HIGH = 1'b1
    } gf_level_e;

endpackage

// File: rtl/gf_width_stage.sv
module gf_width_stage #(
    parameter int unsigned MIN_HI = 1,
    parameter int unsigned MIN_LO = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int unsigned HD = gf_pkg::gf_max(MIN_HI, MIN_LO) - 1;

    logic [HD:0] win;      // bit k = input k cycles ago
    logic        state_q;
    logic        all_hi;
    logic        all_lo;
    logic        dout_c;

    generate
        if (HD > 0) begin : g_hist
            logic [HD-1:0] hist_q;
            always_ff @(posedge clk) begin
                if (rst) hist_q <= '0;
                else     hist_q <= win[HD-1:0];
            end
            assign win = {hist_q, din};
        end else begin : g_nohist
            assign win = din;
        end
    endgenerate

    assign all_hi = &win[MIN_HI-1:0];
    assign all_lo = ~|win[MIN_LO-1:0];

    always_comb begin
        if (rst)         dout_c = 1'b0;
        else if (all_hi) dout_c = 1'b1;
        else if (all_lo) dout_c = 1'b0;
        else             dout_c = state_q;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= 1'b0;
        else     state_q <= dout_c;
    end

    assign dout = dout_c;
endmodule

// File: rtl/gf_hold_stage.sv
module gf_hold_stage #(
    parameter int unsigned KEEP_HI = 1,
    parameter int unsigned KEEP_LO = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int unsigned CW = gf_pkg::gf_cnt_w(gf_pkg::gf_max(KEEP_HI, KEEP_LO));
    localparam logic [CW-1:0] RELOAD_HI = CW'(KEEP_HI - 1);
    localparam logic [CW-1:0] RELOAD_LO = CW'(KEEP_LO - 1);

    typedef struct packed {
        gf_pkg::gf_level_e lvl;
        logic [CW-1:0]     rem;
    } hold_t;

    hold_t st_q;
    hold_t st_d;
    logic  holding;
    logic  y;

    assign holding = (st_q.rem != '0);

    always_comb begin
        if (rst)          y = 1'b0;
        else if (holding) y = st_q.lvl;
        else              y = din;
    end

    always_comb begin
        st_d = st_q;
        if (y != st_q.lvl) begin
            st_d.lvl = gf_pkg::gf_level_e'(y);
            st_d.rem = y ? RELOAD_HI : RELOAD_LO;
        end else if (holding) begin
            st_d.rem = st_q.rem - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{lvl: gf_pkg::GF_LOW, rem: '0};
        else     st_q <= st_d;
    end

    assign dout = y;
endmodule

// File: rtl/gf_glitch_filter.sv
module gf_glitch_filter #(
    parameter int unsigned MIN_HI  = 1,
    parameter int unsigned MIN_LO  = 1,
    parameter int unsigned KEEP_HI = 4,
    parameter int unsigned KEEP_LO = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic width_out;

    gf_width_stage #(.MIN_HI(MIN_HI), .MIN_LO(MIN_LO)) u_width (
        .clk (clk),
        .rst (rst),
        .din (din),
        .dout(width_out)
    );

    gf_hold_stage #(.KEEP_HI(KEEP_HI), .KEEP_LO(KEEP_LO)) u_hold (
        .clk (clk),
        .rst (rst),
        .din (width_out),
        .dout(dout)
    );
endmodule

// File: rtl/gf_glitch_filter_chk.sv
module gf_glitch_filter_chk #(
    parameter int unsigned MIN_HI  = 1,
    parameter int unsigned MIN_LO  = 1,
    parameter int unsigned KEEP_HI = 4,
    parameter int unsigned KEEP_LO = 4
) (
    input logic clk,
    input logic rst,
    input logic din,
    input logic mid,
    input logic dout
);
    localparam int unsigned RW = gf_pkg::gf_cnt_w(gf_pkg::gf_max(MIN_HI, MIN_LO));
    localparam int unsigned KW = gf_pkg::gf_cnt_w(gf_pkg::gf_max(KEEP_HI, KEEP_LO));

    // Runs of equal input samples, saturating.
    logic [RW-1:0] run_hi_q, run_lo_q, run_hi_c, run_lo_c;
    assign run_hi_c = din  ? ((run_hi_q >= RW'(MIN_HI)) ? RW'(MIN_HI) : run_hi_q + 1'b1) : '0;
    assign run_lo_c = !din ? ((run_lo_q >= RW'(MIN_LO)) ? RW'(MIN_LO) : run_lo_q + 1'b1) : '0;

    // Independent hold window tracker on the output.
    logic          prev_q;
    logic          win_lvl_q;
    logic [KW-1:0] win_rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_hi_q  <= '0;
            run_lo_q  <= RW'(MIN_LO);
            prev_q    <= 1'b0;
            win_lvl_q <= 1'b0;
            win_rem_q <= '0;
        end else begin
            run_hi_q <= run_hi_c;
            run_lo_q <= run_lo_c;
            prev_q   <= dout;
            if (dout != prev_q) begin
                win_lvl_q <= dout;
                win_rem_q <= dout ? KW'(KEEP_HI - 1) : KW'(KEEP_LO - 1);
            end else if (win_rem_q != '0) begin
                win_rem_q <= win_rem_q - 1'b1;
            end
        end
    end

    a_r10_reset_low: assert property (@(posedge clk) rst |-> (!dout && !mid));

    a_r2_rise_needs_run: assert property (@(posedge clk) disable iff (rst)
        $rose(mid) |-> (run_hi_c >= RW'(MIN_HI)));

    a_r4_fall_needs_run: assert property (@(posedge clk) disable iff (rst)
        $fell(mid) |-> (run_lo_c >= RW'(MIN_LO)));

    a_r5_hold_high: assert property (@(posedge clk) disable iff (rst)
        (win_rem_q != '0 && win_lvl_q) |-> dout);

    a_r6_hold_low: assert property (@(posedge clk) disable iff (rst)
        (win_rem_q != '0 && !win_lvl_q) |-> !dout);

    a_r8_follow_after_hold: assert property (@(posedge clk) disable iff (rst)
        (win_rem_q == '0) |-> (dout == mid));

    generate
        if (MIN_HI == 1 && MIN_LO == 1 && KEEP_HI == 1 && KEEP_LO == 1) begin : g_pass
            a_r1_transparent: assert property (@(posedge clk) disable iff (rst) dout == din);
        end
    endgenerate
endmodule

bind gf_glitch_filter gf_glitch_filter_chk #(
    .MIN_HI(MIN_HI), .MIN_LO(MIN_LO), .KEEP_HI(KEEP_HI), .KEEP_LO(KEEP_LO)
) u_chk (
    .clk (clk),
    .rst (rst),
    .din (din),
    .mid (width_out),
    .dout(dout)
);

// File: tb/gf_glitch_filter_tb.sv
`timescale 1ns/1ps
module gf_glitch_filter_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic dout_mix, dout_pass, dout_dep;

    always #4 clk = ~clk;

    gf_glitch_filter #(.MIN_HI(2), .MIN_LO(3), .KEEP_HI(4), .KEEP_LO(2)) dut_i (
        .clk(clk), .rst(rst), .din(din), .dout(dout_mix));
    gf_glitch_filter #(.MIN_HI(1), .MIN_LO(1), .KEEP_HI(1), .KEEP_LO(1)) dut_pass (
        .clk(clk), .rst(rst), .din(din), .dout(dout_pass));
    gf_glitch_filter dut_dep (
        .clk(clk), .rst(rst), .din(din), .dout(dout_dep));

    int cfg_mh[3] = '{2, 1, 1};
    int cfg_ml[3] = '{3, 1, 1};
    int cfg_kh[3] = '{4, 1, 4};
    int cfg_kl[3] = '{2, 1, 4};

    int   n_cmp = 0;
    int   n_bad = 0;
    int   hist[$];
    logic m_mid[3];
    logic m_lvl[3];
    int   m_rem[3];
    string tag = "R10";

    function automatic logic run_of(int n, int v);
        for (int i = 0; i < n; i++) begin
            int h = (i < hist.size()) ? hist[i] : 0;
            if (h != v) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic act(int c);
        return (c == 0) ? dout_mix : (c == 1) ? dout_pass : dout_dep;
    endfunction

    task automatic compare(int c, logic exp_v, string t);
        logic a = act(c);
        n_cmp++;
        if (a !== exp_v) begin
            n_bad++;
            $display("FAIL %s cfg%0d cycle %0d: actual %b expected %b", t, c, n_cmp, a, exp_v);
        end
    endtask

    task automatic tick(logic r, logic v);
        @(negedge clk);
        rst = r;
        din = v;
        #1;
        if (r) begin
            hist.delete();
            for (int c = 0; c < 3; c++) begin
                m_mid[c] = 1'b0; m_lvl[c] = 1'b0; m_rem[c] = 0;
                compare(c, 1'b0, "R10");
            end
        end else begin
            hist.push_front(int'(v));
            if (hist.size() > 8) void'(hist.pop_back());
            for (int c = 0; c < 3; c++) begin
                logic mid, y;
                mid = run_of(cfg_mh[c], 1) ? 1'b1 : run_of(cfg_ml[c], 0) ? 1'b0 : m_mid[c];
                y = (m_rem[c] > 0) ? m_lvl[c] : mid;
                compare(c, y, (c == 1) ? "R1 R7" : tag);
                if (y != m_lvl[c]) m_rem[c] = (y ? cfg_kh[c] : cfg_kl[c]) - 1;
                else if (m_rem[c] > 0) m_rem[c]--;
                m_lvl[c] = y;
                m_mid[c] = mid;
            end
        end
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        string pat;
        logic [15:0] lfsr;
        // R10: output low in reset, even with input high
        tick(1'b1, 1'b1); tick(1'b1, 1'b1); tick(1'b1, 1'b0);
        // R2 R3 R5: positive pulses of growing width
        tag = "R2 R3 R5";
        for (int w = 1; w <= 6; w++) begin
            for (int i = 0; i < w; i++) tick(1'b0, 1'b1);
            for (int i = 0; i < 8; i++) tick(1'b0, 1'b0);
        end
        // R4 R6: negative gaps of growing width
        tag = "R4 R6";
        for (int w = 1; w <= 6; w++) begin
            for (int i = 0; i < 8; i++) tick(1'b0, 1'b1);
            for (int i = 0; i < w; i++) tick(1'b0, 1'b0);
        end
        for (int i = 0; i < 8; i++) tick(1'b0, 1'b0);
        // R8 R9: glitchy edges where holds end on changed levels
        tag = "R8 R9";
        pat = "0110111000101100111101001110000011010111100";
        for (int i = 0; i < pat.len(); i++) tick(1'b0, pat[i] == "1");
        // R8 R9: pseudo-random noise
        lfsr = 16'hACE1;
        for (int i = 0; i < 500; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tick(1'b0, lfsr[0] & (lfsr[3] | lfsr[5]));
        end
        // R10: reset in the middle of a hold period
        tag = "R10";
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b1);
        tick(1'b1, 1'b1); tick(1'b1, 1'b1);
        tick(1'b0, 1'b1); tick(1'b0, 1'b0); tick(1'b0, 1'b1); tick(1'b0, 1'b1);
        for (int i = 0; i < 10; i++) tick(1'b0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule